// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines and steers each one to any subset of four processors. Software programs it through two 32-bit register windows addressed by byte offset: a shared window common to all processors and a per-processor window. Its write port and read port are separate. A processor chooses its window with a CPU-select field on each port.

A line is turned on or off with a single index write to a set register or a clear register. It is hidden from or shown to one processor the same way. There is no read-modify-write of bitmaps. Every line also has a routing word that sends it to each processor as a normal request, as a fast request, or as both.

Lines 0 to 31 are private, so each processor has its own copy of them. Line 4 carries a cascaded error group, gated per processor by an error-enable mask. Line 96 carries the summary of an external message-doorbell block. Each processor reads an acknowledge register that returns the lowest-numbered line eligible for it.

Top module: `mcpu_intc`

## Requirements
- R1: After a synchronous reset every line is disabled and masked on every CPU, every routing word reads 0, the controller is off, the current-priority registers read 0, irq_o and fiq_o are all low and every acknowledge read returns 0x3ff.
- R2: A shared write of value n to offset 0x30 enables line n. A shared write of n to offset 0x34 disables line n for all CPUs.
- R3: A per-CPU write of n to offset 0x48 masks line n for that CPU only. A write of n to offset 0x4c unmasks it for that CPU only.
- R4: The routing word of line n sits at shared offset 0x100 + 4n. Bit c sends the line to CPU c on irq_o[c], and bit c+8 sends it on fiq_o[c]. The word reads back what was written in those bits.
- R5: A line is eligible for CPU c when the controller is on, the line is enabled, unmasked for c, routed to c and asserted. A per-CPU read of offset 0x44 returns the lowest eligible line number in bits [9:0], or 0x3ff when none is eligible. Reading it does not clear anything.
- R6: Shared offset 0x0 reads the number of lines (128) in bits [11:2] and the controller-on flag in bit 0. Writing bit 0 turns the controller on or off. While it is off, every irq_o and fiq_o is low.
- R7: Line 4 for CPU c is the OR of err_in ANDed with CPU c's error-enable mask at per-CPU offset 0xe50. The raw err_in reads at shared offset 0x20.
- R8: Lines 0 to 31 of CPU c come from priv_in[32c+31:32c]. A per-CPU read of offset 0x10 returns that CPU's 32 private lines.
- R9: An index write to 0x30, 0x34, 0x48 or 0x4c with a value of 128 or more changes nothing.
- R10: A write takes effect at the next clock edge. A read in the same cycle as a write returns the state from before that write.
- R11: Per-CPU offset 0x40 is a 32-bit current-priority register per CPU. It is written and read back independently for each CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_percpu | input | 1 | 1 selects the per-CPU window, 0 the shared window |
| wr_cpu | input | 2 | CPU whose per-CPU window is written |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_percpu | input | 1 | 1 selects the per-CPU window for reads |
| rd_cpu | input | 2 | CPU whose per-CPU window is read |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from the read address |
| priv_in | input | 128 | Private lines 0..31, 32 per CPU |
| shr_in | input | 96 | Shared lines 32..127; bit k is line 32+k |
| err_in | input | 32 | Error-group causes feeding line 4 |
| irq_o | output | 4 | Normal request per CPU |
| fiq_o | output | 4 | Fast request per CPU |

## Verification
A register write and an acknowledge read can land in the same cycle, because the two ports are independent. The bench provokes this by driving a per-CPU mask write of an eligible line together with an acknowledge read on that CPU. In that cycle the read must still return the line. After the edge it must return 0x3ff. The same ordering shows on irq_o, which must drop only after the edge.

// File: rtl/mcpu_intc_pkg.sv
package mcpu_intc_pkg;
    // Shared window offsets
    localparam int OFS_CTRL       = 'h000;
    localparam int OFS_ERR_CAUSE  = 'h020;
    localparam int OFS_EN_SET     = 'h030;
    localparam int OFS_EN_CLR     = 'h034;
    localparam int OFS_ROUTE_BASE = 'h100;
    // Per-CPU window offsets
    localparam int OFS_PRIV_CAUSE = 'h010;
    localparam int OFS_PRIO       = 'h040;
    localparam int OFS_ACK        = 'h044;
    localparam int OFS_MASK_SET   = 'h048;
    localparam int OFS_MASK_CLR   = 'h04c;
    localparam int OFS_ERR_MASK   = 'he50;

    localparam int ID_W     = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'h3ff;
    localparam int FAST_OFS = 8;
    localparam int ERR_LINE = 4;
endpackage

// File: rtl/mcpu_intc_regs.sv
module mcpu_intc_regs
    import mcpu_intc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 128,
    parameter int NERR = 32,
    parameter int AW   = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            wr_percpu,
    input  logic [$clog2(NCPU)-1:0]         wr_cpu,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [31:0]                     wr_data,
    output logic                            ctl_en_q,
    output logic [NSRC-1:0]                 en_q,
    output logic [NCPU-1:0][NSRC-1:0]       msk_q,
    output logic [NSRC-1:0][NCPU-1:0]       rirq_q,
    output logic [NSRC-1:0][NCPU-1:0]       rfiq_q,
    output logic [NCPU-1:0][NERR-1:0]       emsk_q,
    output logic [NCPU-1:0][31:0]           prio_q
);
    localparam int IW = $clog2(NSRC);

    typedef struct packed {
        logic                      ctl_en;
        logic [NSRC-1:0]           en;
        logic [NCPU-1:0][NSRC-1:0] msk;
        logic [NSRC-1:0][NCPU-1:0] rirq;
        logic [NSRC-1:0][NCPU-1:0] rfiq;
        logic [NCPU-1:0][NERR-1:0] emsk;
        logic [NCPU-1:0][31:0]     prio;
    } state_t;

    state_t st_d, st_q;

    logic          idx_ok;
    logic [IW-1:0] idx;
    logic [AW-1:0] roff;
    logic          route_hit;
    logic [IW-1:0] ridx;

    always_comb begin
        st_d      = st_q;
        idx_ok    = wr_data < 32'(NSRC);
        idx       = wr_data[IW-1:0];
        roff      = wr_addr - AW'(OFS_ROUTE_BASE);
        route_hit = (roff[1:0] == 2'b00) && (int'(roff[AW-1:2]) < NSRC);
        ridx      = roff[IW+1:2];
        if (wr_en) begin
            if (!wr_percpu) begin
                if (wr_addr == AW'(OFS_CTRL)) begin
                    st_d.ctl_en = wr_data[0];
                end else if (wr_addr == AW'(OFS_EN_SET)) begin
                    if (idx_ok) st_d.en[idx] = 1'b1;
                end else if (wr_addr == AW'(OFS_EN_CLR)) begin
                    if (idx_ok) st_d.en[idx] = 1'b0;
                end else if (route_hit) begin
                    for (int c = 0; c < NCPU; c++) begin
                        st_d.rirq[ridx][c] = wr_data[c];
                        st_d.rfiq[ridx][c] = wr_data[FAST_OFS+c];
                    end
                end
            end else begin
                if (wr_addr == AW'(OFS_MASK_SET)) begin
                    if (idx_ok) st_d.msk[wr_cpu][idx] = 1'b1;
                end else if (wr_addr == AW'(OFS_MASK_CLR)) begin
                    if (idx_ok) st_d.msk[wr_cpu][idx] = 1'b0;
                end else if (wr_addr == AW'(OFS_PRIO)) begin
                    st_d.prio[wr_cpu] = wr_data;
                end else if (wr_addr == AW'(OFS_ERR_MASK)) begin
                    st_d.emsk[wr_cpu] = wr_data[NERR-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.msk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_en_q = st_q.ctl_en;
    assign en_q     = st_q.en;
    assign msk_q    = st_q.msk;
    assign rirq_q   = st_q.rirq;
    assign rfiq_q   = st_q.rfiq;
    assign emsk_q   = st_q.emsk;
    assign prio_q   = st_q.prio;
endmodule

// File: rtl/mcpu_intc_pick.sv
module mcpu_intc_pick
    import mcpu_intc_pkg::*;
#(
    parameter int NSRC = 128
) (
    input  logic             ctl_en,
    input  logic [NSRC-1:0]  line,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  msk,
    input  logic [NSRC-1:0]  rirq,
    input  logic [NSRC-1:0]  rfiq,
    output logic             irq,
    output logic             fiq,
    output logic [ID_W-1:0]  ack_id
);
    logic [NSRC-1:0] elig;

    always_comb begin
        elig   = {NSRC{ctl_en}} & line & en & ~msk & (rirq | rfiq);
        irq    = |(elig & rirq);
        fiq    = |(elig & rfiq);
        ack_id = ID_NONE;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (elig[n]) ack_id = ID_W'(n);
        end
    end
endmodule

// File: rtl/mcpu_intc.sv
module mcpu_intc
    import mcpu_intc_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NSRC  = 128,
    parameter int NPRIV = 32,
    parameter int NERR  = 32,
    parameter int AW    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_percpu,
    input  logic [$clog2(NCPU)-1:0]  wr_cpu,
    input  logic [AW-1:0]            wr_addr,
    input  logic [31:0]              wr_data,
    input  logic                     rd_percpu,
    input  logic [$clog2(NCPU)-1:0]  rd_cpu,
    input  logic [AW-1:0]            rd_addr,
    output logic [31:0]              rd_data,
    input  logic [NCPU*NPRIV-1:0]    priv_in,
    input  logic [NSRC-NPRIV-1:0]    shr_in,
    input  logic [NERR-1:0]          err_in,
    output logic [NCPU-1:0]          irq_o,
    output logic [NCPU-1:0]          fiq_o
);
    localparam int IW = $clog2(NSRC);

    logic                        ctl_en_q;
    logic [NSRC-1:0]             en_q;
    logic [NCPU-1:0][NSRC-1:0]   msk_q;
    logic [NSRC-1:0][NCPU-1:0]   rirq_q;
    logic [NSRC-1:0][NCPU-1:0]   rfiq_q;
    logic [NCPU-1:0][NERR-1:0]   emsk_q;
    logic [NCPU-1:0][31:0]       prio_q;
    logic [NCPU-1:0][ID_W-1:0]   ack_id;

    mcpu_intc_regs #(.NCPU(NCPU), .NSRC(NSRC), .NERR(NERR), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_percpu(wr_percpu),
        .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_en_q(ctl_en_q), .en_q(en_q), .msk_q(msk_q), .rirq_q(rirq_q),
        .rfiq_q(rfiq_q), .emsk_q(emsk_q), .prio_q(prio_q)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] line_c, rirq_c, rfiq_c;
        logic            err_sum;

        always_comb begin
            err_sum = |(err_in & emsk_q[c]);
            line_c  = {shr_in, priv_in[c*NPRIV +: NPRIV]};
            line_c[ERR_LINE] = err_sum;
            for (int n = 0; n < NSRC; n++) begin
                rirq_c[n] = rirq_q[n][c];
                rfiq_c[n] = rfiq_q[n][c];
            end
        end

        mcpu_intc_pick #(.NSRC(NSRC)) u_pick (
            .ctl_en(ctl_en_q), .line(line_c), .en(en_q), .msk(msk_q[c]),
            .rirq(rirq_c), .rfiq(rfiq_c), .irq(irq_o[c]), .fiq(fiq_o[c]),
            .ack_id(ack_id[c])
        );
    end

    logic [AW-1:0] roff;
    logic          rhit;
    logic [IW-1:0] ridx;

    always_comb begin
        rd_data = '0;
        roff    = rd_addr - AW'(OFS_ROUTE_BASE);
        rhit    = (roff[1:0] == 2'b00) && (int'(roff[AW-1:2]) < NSRC);
        ridx    = roff[IW+1:2];
        if (!rd_percpu) begin
            if (rd_addr == AW'(OFS_CTRL)) begin
                rd_data[11:2] = 10'(NSRC);
                rd_data[0]    = ctl_en_q;
            end else if (rd_addr == AW'(OFS_ERR_CAUSE)) begin
                rd_data[NERR-1:0] = err_in;
            end else if (rhit) begin
                for (int c = 0; c < NCPU; c++) begin
                    rd_data[c]          = rirq_q[ridx][c];
                    rd_data[FAST_OFS+c] = rfiq_q[ridx][c];
                end
            end
        end else begin
            if (rd_addr == AW'(OFS_PRIV_CAUSE)) begin
                rd_data[NPRIV-1:0] = priv_in[rd_cpu*NPRIV +: NPRIV];
            end else if (rd_addr == AW'(OFS_PRIO)) begin
                rd_data = prio_q[rd_cpu];
            end else if (rd_addr == AW'(OFS_ACK)) begin
                rd_data[ID_W-1:0] = ack_id[rd_cpu];
            end else if (rd_addr == AW'(OFS_ERR_MASK)) begin
                rd_data[NERR-1:0] = emsk_q[rd_cpu];
            end
        end
    end
endmodule

// File: rtl/mcpu_intc_chk.sv
module mcpu_intc_chk
    import mcpu_intc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 128,
    parameter int AW   = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic                       wr_percpu,
    input logic [$clog2(NCPU)-1:0]    wr_cpu,
    input logic [AW-1:0]              wr_addr,
    input logic [31:0]                wr_data,
    input logic                       rd_percpu,
    input logic [$clog2(NCPU)-1:0]    rd_cpu,
    input logic [AW-1:0]              rd_addr,
    input logic [31:0]                rd_data,
    input logic [NCPU-1:0]            irq_o,
    input logic [NCPU-1:0]            fiq_o,
    input logic [NSRC-1:0]            en_q,
    input logic [NCPU-1:0][NSRC-1:0]  msk_q
);
    localparam int IW = $clog2(NSRC);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (irq_o == '0 && fiq_o == '0));

    assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_percpu && wr_addr == AW'(OFS_EN_SET) && wr_data < 32'(NSRC))
        |=> en_q[$past(wr_data[IW-1:0])]);

    assert_enable_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_percpu && wr_addr == AW'(OFS_EN_CLR) && wr_data < 32'(NSRC))
        |=> !en_q[$past(wr_data[IW-1:0])]);

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_percpu && wr_addr == AW'(OFS_MASK_SET) && wr_data < 32'(NSRC))
        |=> msk_q[$past(wr_cpu)][$past(wr_data[IW-1:0])]);

    assert_idle_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_percpu && rd_addr == AW'(OFS_ACK) && !irq_o[rd_cpu] && !fiq_o[rd_cpu])
        |-> rd_data == 32'h3ff);

    assert_ack_range_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_percpu && rd_addr == AW'(OFS_ACK))
        |-> (rd_data < 32'(NSRC) || rd_data == 32'h3ff));

    assert_ctl_off_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_percpu && wr_addr == AW'(OFS_CTRL) && !wr_data[0])
        |=> (irq_o == '0 && fiq_o == '0));
endmodule

bind mcpu_intc mcpu_intc_chk #(.NCPU(NCPU), .NSRC(NSRC), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_percpu(wr_percpu),
    .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_percpu(rd_percpu), .rd_cpu(rd_cpu), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o),
    .en_q(en_q), .msk_q(msk_q)
);

// File: tb/mcpu_intc_tb.sv
module mcpu_intc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_percpu = 1'b0;
    logic [1:0]  wr_cpu = '0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_percpu = 1'b0;
    logic [1:0]  rd_cpu = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [127:0] priv_in = '0;
    logic [95:0]  shr_in = '0;
    logic [31:0]  err_in = '0;
    logic [3:0]   irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mcpu_intc u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_percpu(wr_percpu),
        .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_percpu(rd_percpu), .rd_cpu(rd_cpu), .rd_addr(rd_addr),
        .rd_data(rd_data), .priv_in(priv_in), .shr_in(shr_in),
        .err_in(err_in), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic pc, input int cpu, input int addr, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_percpu = pc; wr_cpu = 2'(cpu); wr_addr = 12'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic pc, input int cpu, input int addr, output logic [31:0] v);
        rd_percpu = pc; rd_cpu = 2'(cpu); rd_addr = 12'(addr);
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", 32'(irq_o), 0);
        check("R1 fiq", 32'(fiq_o), 0);
        rd(1, 0, 'h44, v); check("R1 ack cpu0", v, 32'h3ff);
        rd(0, 0, 'h1a0, v); check("R1 route40", v, 0);
        rd(0, 0, 'h000, v); check("R6 ctrl count", v, 32'h200);
        rd(1, 3, 'h040, v); check("R1 prio cpu3", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(0, 0, 'h000, 1);
        rd(0, 0, 'h000, v); check("R6 ctrl on", v, 32'h201);
        shr_in[40-32] = 1'b1;
        wr(0, 0, 'h030, 40);
        wr(0, 0, 'h1a0, 32'h2);
        check("R3 still masked", 32'(irq_o), 0);
        wr(1, 1, 'h04c, 40);
        check("R4 irq cpu1", 32'(irq_o), 32'h2);
        rd(1, 1, 'h44, v); check("R5 ack cpu1", v, 40);
        rd(1, 1, 'h44, v); check("R5 ack repeat", v, 40);
        rd(1, 0, 'h44, v); check("R5 ack cpu0 none", v, 32'h3ff);
        rd(0, 0, 'h1a0, v); check("R4 route readback", v, 32'h2);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(1, 1, 'h048, 40);
        check("R3 masked irq", 32'(irq_o), 0);
        rd(1, 1, 'h44, v); check("R3 masked ack", v, 32'h3ff);
        wr(1, 1, 'h04c, 40);
        check("R3 unmasked irq", 32'(irq_o), 32'h2);
        wr(0, 0, 'h034, 40);
        check("R2 disabled irq", 32'(irq_o), 0);
        wr(0, 0, 'h030, 40);
        check("R2 reenabled irq", 32'(irq_o), 32'h2);
    endtask

    task automatic t_fast();
        wr(0, 0, 'h1a0, 32'h402);
        wr(1, 2, 'h04c, 40);
        check("R4 fast cpu2", 32'(fiq_o), 32'h4);
        check("R4 normal cpu1 only", 32'(irq_o), 32'h2);
    endtask

    task automatic t_order();
        logic [31:0] v;
        shr_in[35-32] = 1'b1;
        wr(0, 0, 'h030, 35);
        wr(0, 0, 'h18c, 32'h2);
        wr(1, 1, 'h04c, 35);
        rd(1, 1, 'h44, v); check("R5 lowest wins", v, 35);
        shr_in[35-32] = 1'b0;
        rd(1, 1, 'h44, v); check("R5 next after drop", v, 40);
    endtask

    task automatic t_priv();
        logic [31:0] v;
        priv_in[3*32+7] = 1'b1;
        wr(0, 0, 'h030, 7);
        wr(0, 0, 'h11c, 32'h9);
        wr(1, 0, 'h04c, 7);
        wr(1, 3, 'h04c, 7);
        check("R8 private cpu3 only", 32'(irq_o), 32'ha);
        rd(1, 3, 'h44, v); check("R8 ack cpu3", v, 7);
        rd(1, 3, 'h010, v); check("R8 cause cpu3", v, 32'h80);
        rd(1, 0, 'h010, v); check("R8 cause cpu0", v, 0);
        priv_in[3*32+7] = 1'b0;
        #1;
        check("R8 private released", 32'(irq_o), 32'h2);
    endtask

    task automatic t_err();
        logic [31:0] v;
        err_in = 32'h4;
        wr(0, 0, 'h030, 4);
        wr(0, 0, 'h110, 32'h1);
        wr(1, 0, 'h04c, 4);
        rd(1, 0, 'h44, v); check("R7 err gated", v, 32'h3ff);
        wr(1, 0, 'he50, 32'h4);
        rd(1, 0, 'h44, v); check("R7 err ack", v, 4);
        check("R7 err irq", 32'(irq_o), 32'h3);
        rd(0, 0, 'h020, v); check("R7 err cause", v, 32'h4);
        rd(1, 0, 'he50, v); check("R7 err mask readback", v, 32'h4);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(0, 0, 'h000, 0);
        check("R6 off irq", 32'(irq_o), 0);
        check("R6 off fiq", 32'(fiq_o), 0);
        rd(1, 1, 'h44, v); check("R6 off ack", v, 32'h3ff);
        wr(0, 0, 'h000, 1);
        check("R6 on again", 32'(irq_o), 32'h3);
    endtask

    task automatic t_oob();
        logic [31:0] v;
        wr(0, 0, 'h034, 168);
        wr(1, 1, 'h048, 168);
        check("R9 out of range ignored", 32'(irq_o), 32'h3);
        rd(1, 1, 'h44, v); check("R9 ack unchanged", v, 40);
    endtask

    task automatic t_same();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_percpu = 1'b1; wr_cpu = 2'd1; wr_addr = 12'h048; wr_data = 40;
        rd(1, 1, 'h44, v); check("R10 read sees old", v, 40);
        check("R10 irq before edge", 32'(irq_o), 32'h3);
        @(negedge clk);
        wr_en = 1'b0;
        rd(1, 1, 'h44, v); check("R10 read after edge", v, 32'h3ff);
        check("R10 irq after edge", 32'(irq_o), 32'h1);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(1, 2, 'h040, 5);
        rd(1, 2, 'h040, v); check("R11 prio cpu2", v, 5);
        rd(1, 1, 'h040, v); check("R11 prio cpu1", v, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_mask();
        t_fast();
        t_order();
        t_priv();
        t_err();
        t_ctrl();
        t_oob();
        t_same();
        t_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule